// File: doc/BRIEF.md
# Piecewise-Linear Gamma Correction

This block maps a stream of 10-bit RGB pixels through a gamma curve. Each colour channel has its own curve, held as 64 linear segments. The upper six bits of an input sample pick a segment. The lower four bits give the position inside that segment. The result is the segment's starting value plus its slope scaled by that position. Any result above the 10-bit range is clipped to full scale.

Software fills the three curve tables through a one-word write port. Each table word carries a starting value and a slope. Changing the curve means rewriting the tables, and rewrites may happen while pixels are flowing. A pixel then sees a new entry from the cycle after the write. Pixels travel through a fixed two-stage pipeline, and a valid flag marks each one.

Top module: `gamma_curve`

## Requirements
- R1: Write word address bits [9:8] select the table: 0 is blue, 1 is green and 2 is red. Bits [5:0] select the entry within that table, and a write changes only that one entry.
- R2: In a table word, bits [25:16] are the segment's starting value and bits [9:0] are its slope. All other bits of the word are ignored.
- R3: For a channel input p, seg = p[9:4] and off = p[3:0]. The output is base[seg] + ((slope[seg] * off) >> 4), where base and slope come from that channel's table.
- R4: When the sum in R3 exceeds 1023, the output is 1023.
- R5: A pixel presented with inValid high in cycle c appears on the outputs with outValid high in cycle c+2. outValid is low in cycle c+2 whenever inValid was low in cycle c.
- R6: While outValid is low, outR, outG and outB hold their previous values.
- R7: A table write in cycle c is used by pixels presented in cycle c+1 and later. A pixel presented in cycle c, the same cycle as the write, still uses the old entry.
- R8: A write is ignored when address bits [9:8] equal 3, or when address bits [7:6] are not zero.
- R9: After reset, outValid is low, the outputs are zero and every table entry is zero, so every pixel maps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel qualifier |
| inR | input | 10 | Red input sample |
| inG | input | 10 | Green input sample |
| inB | input | 10 | Blue input sample |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | 10 | Table word address |
| wrData | input | 32 | Table word (starting value and slope) |
| outValid | output | 1 | Output pixel qualifier |
| outR | output | 10 | Corrected red sample |
| outG | output | 10 | Corrected green sample |
| outB | output | 10 | Corrected blue sample |

## Verification
The bench loads tables that differ per channel and fills the unused word bits with noise. A design that swaps channel selects or misplaces a field would then produce visibly wrong curves. The red table is built so that its top segments overflow, which catches a wrap instead of a clip. A write lands on the segment of the pixel presented in the same cycle, so a design that forwards the new entry too early, or applies it a cycle late, mismatches on one of the two adjacent pixels. Writes to the reserved address ranges are followed by pixels in the targeted segment, so a loose address decode corrupts the output. Gaps in inValid carrying changing noise expose outputs that fail to hold or a pipeline whose depth is wrong.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  parameter int PIX_W     = 10;  // sample width
  parameter int SEG_W     = 6;   // segment index width
  parameter int FIELD_W   = 10;  // base and slope field width
  parameter int ENTRY_W   = 32;  // table word width
  parameter int BASE_LSB  = 16;  // base field position
  parameter int SLOPE_LSB = 0;   // slope field position
  parameter int ADDR_W    = 10;  // word address width
  parameter int SEL_W     = 2;   // table select width
  parameter int NUM_CH    = 3;   // colour channels: 0 blue, 1 green, 2 red

  typedef struct packed {
    logic [NUM_CH-1:0]  chanWe;
    logic [SEG_W-1:0]   idx;
    logic [FIELD_W-1:0] base;
    logic [FIELD_W-1:0] slope;
    logic               stage1En;
    logic               stage2En;
  } gammaCtrl_t;
endpackage

// File: rtl/gamma_ctrl.sv
module gamma_ctrl
  import gamma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ENTRY_W-1:0] wrData,
  output gammaCtrl_t        ctrl,
  output logic              outValid
);
  localparam int SEL_LSB = ADDR_W - SEL_W;
  localparam int PAD_W   = SEL_LSB - SEG_W;

  logic [SEL_W-1:0] tblSel;
  logic             padClear;
  logic             v1Q, v2Q;
  logic             unusedEntryBits;

  assign tblSel = wrAddr[ADDR_W-1:SEL_LSB];

  generate
    if (PAD_W > 0) begin : g_pad
      assign padClear = (wrAddr[SEL_LSB-1:SEG_W] == '0);
    end else begin : g_nopad
      assign padClear = 1'b1;
    end
  endgenerate

  assign unusedEntryBits = ^{wrData[ENTRY_W-1:BASE_LSB+FIELD_W],
                             wrData[BASE_LSB-1:SLOPE_LSB+FIELD_W]};

  always_comb begin
    ctrl = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      ctrl.chanWe[c] = wrEn && padClear && (int'(tblSel) == c);
    end
    ctrl.idx      = wrAddr[SEG_W-1:0];
    ctrl.base     = wrData[BASE_LSB +: FIELD_W];
    ctrl.slope    = wrData[SLOPE_LSB +: FIELD_W];
    ctrl.stage1En = inValid;
    ctrl.stage2En = v1Q;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1Q <= 1'b0;
      v2Q <= 1'b0;
    end else begin
      v1Q <= inValid;
      v2Q <= v1Q;
    end
  end

  assign outValid = v2Q;
endmodule

// File: rtl/gamma_datapath.sv
module gamma_datapath
  import gamma_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  gammaCtrl_t              ctrl,
  input  logic [NUM_CH*PIX_W-1:0] pixIn,
  output logic [NUM_CH*PIX_W-1:0] pixOut
);
  localparam int OFF_W   = PIX_W - SEG_W;
  localparam int DEPTH   = 1 << SEG_W;
  localparam int PROD_W  = FIELD_W + OFF_W;
  localparam int SUM_W   = FIELD_W + 1;
  localparam int MAX_OUT = (1 << PIX_W) - 1;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    logic [FIELD_W-1:0] baseMem  [DEPTH];
    logic [FIELD_W-1:0] slopeMem [DEPTH];
    logic [PIX_W-1:0]   pix;
    logic [SEG_W-1:0]   seg;
    logic [OFF_W-1:0]   off;
    logic [FIELD_W-1:0] segBaseQ, segSlopeQ;
    logic [OFF_W-1:0]   offQ;
    logic [PROD_W-1:0]  prod;
    logic [FIELD_W-1:0] scaled;
    logic [SUM_W-1:0]   sum;
    logic [PIX_W-1:0]   satVal, outQ;
    logic               unusedProdLsb;

    assign pix = pixIn[ch*PIX_W +: PIX_W];
    assign seg = pix[PIX_W-1:OFF_W];
    assign off = pix[OFF_W-1:0];

    // table storage, written one entry per cycle
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) begin
          baseMem[i]  <= '0;
          slopeMem[i] <= '0;
        end
      end else if (ctrl.chanWe[ch]) begin
        baseMem[ctrl.idx]  <= ctrl.base;
        slopeMem[ctrl.idx] <= ctrl.slope;
      end
    end

    // stage 1: segment lookup
    always_ff @(posedge clk) begin
      if (!rstN) begin
        segBaseQ  <= '0;
        segSlopeQ <= '0;
        offQ      <= '0;
      end else if (ctrl.stage1En) begin
        segBaseQ  <= baseMem[seg];
        segSlopeQ <= slopeMem[seg];
        offQ      <= off;
      end
    end

    // stage 2: interpolate and clip
    assign prod          = PROD_W'(segSlopeQ) * PROD_W'(offQ);
    assign scaled        = prod[PROD_W-1:OFF_W];
    assign unusedProdLsb = ^prod[OFF_W-1:0];
    assign sum           = SUM_W'(segBaseQ) + SUM_W'(scaled);
    assign satVal        = (sum > SUM_W'(MAX_OUT)) ? PIX_W'(MAX_OUT) : sum[PIX_W-1:0];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        outQ <= '0;
      end else if (ctrl.stage2En) begin
        outQ <= satVal;
      end
    end

    assign pixOut[ch*PIX_W +: PIX_W] = outQ;
  end
endmodule

// File: rtl/gamma_curve.sv
module gamma_curve
  import gamma_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [PIX_W-1:0]   inR,
  input  logic [PIX_W-1:0]   inG,
  input  logic [PIX_W-1:0]   inB,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [ENTRY_W-1:0] wrData,
  output logic               outValid,
  output logic [PIX_W-1:0]   outR,
  output logic [PIX_W-1:0]   outG,
  output logic [PIX_W-1:0]   outB
);
  gammaCtrl_t              ctrl;
  logic [NUM_CH*PIX_W-1:0] pixOut;

  gamma_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  gamma_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .pixIn  ({inR, inG, inB}),
    .pixOut (pixOut)
  );

  assign outB = pixOut[0*PIX_W +: PIX_W];
  assign outG = pixOut[1*PIX_W +: PIX_W];
  assign outR = pixOut[2*PIX_W +: PIX_W];
endmodule

// File: rtl/gamma_curve_chk.sv
module gamma_curve_chk
  import gamma_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             outValid,
  input logic [PIX_W-1:0] outR,
  input logic [PIX_W-1:0] outG,
  input logic [PIX_W-1:0] outB
);
  // R5
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);

  // R5
  idle_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid);

  // R6
  hold_red_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outR));

  // R6
  hold_green_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outG));

  // R6
  hold_blue_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outB));

  // R9
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && outR == '0 && outG == '0 && outB == '0));
endmodule

bind gamma_curve gamma_curve_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .outValid (outValid),
  .outR     (outR),
  .outG     (outG),
  .outB     (outB)
);

// File: tb/gamma_curve_test.sv
module gamma_curve_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [9:0]  inR = '0, inG = '0, inB = '0;
  logic        wrEn = 1'b0;
  logic [9:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        outValid;
  logic [9:0]  outR, outG, outB;

  always #10 clk = ~clk;

  gamma_curve uut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inR(inR), .inG(inG), .inB(inB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .outValid(outValid), .outR(outR), .outG(outG), .outB(outB)
  );

  int    nChecks = 0;
  int    nFail = 0;
  bit    done = 1'b0;
  string tag = "R9";

  // reference state: channel 0 blue, 1 green, 2 red
  int refBase [3][64];
  int refSlope[3][64];
  int s1v = 0, s2v = 0;
  int s1[3];
  int s2[3];

  task automatic check(string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int refOut(int ch, int p);
    int seg = p / 16;
    int off = p % 16;
    int v = refBase[ch][seg] + (refSlope[ch][seg] * off) / 16;
    if (v > 1023) v = 1023;
    return v;
  endfunction

  function automatic int tagWord(int base, int slope);
    return (int'($urandom_range(0, 63)) << 26) | (base << 16) |
           (int'($urandom_range(0, 63)) << 10) | slope;
  endfunction

  task automatic cyc(input bit v, input int r, input int g, input int b,
                     input bit we, input int a, input int d);
    int pix[3];
    @(negedge clk);
    inValid = v; inR = 10'(r); inG = 10'(g); inB = 10'(b);
    wrEn = we; wrAddr = 10'(a); wrData = 32'(d);
    @(posedge clk);
    #2;
    pix[0] = b; pix[1] = g; pix[2] = r;
    if (s1v != 0) s2 = s1;
    s2v = s1v;
    if (v) for (int c = 0; c < 3; c++) s1[c] = refOut(c, pix[c]);
    s1v = v ? 1 : 0;
    if (we && (a / 256) < 3 && ((a / 64) % 4) == 0) begin
      refBase[a / 256][a % 64]  = (d >> 16) & 1023;
      refSlope[a / 256][a % 64] = d & 1023;
    end
    check("outValid", int'(outValid), s2v);
    check("outB", int'(outB), s2[0]);
    check("outG", int'(outG), s2[1]);
    check("outR", int'(outR), s2[2]);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++)
      cyc(0, $urandom_range(0, 1023), $urandom_range(0, 1023), $urandom_range(0, 1023), 0, 0, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    for (int c = 0; c < 3; c++) begin
      s1[c] = 0; s2[c] = 0;
      for (int i = 0; i < 64; i++) begin refBase[c][i] = 0; refSlope[c][i] = 0; end
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R9: reset state at the ports
    tag = "R9";
    check("outValid", int'(outValid), 0);
    check("outR", int'(outR), 0);
    check("outG", int'(outG), 0);
    check("outB", int'(outB), 0);
    for (int k = 0; k < 6; k++)
      cyc(1, $urandom_range(0, 1023), $urandom_range(0, 1023), $urandom_range(0, 1023), 0, 0, 0);
    idle(2);

    // R1 and R2: per-channel tables with noise in unused bits
    tag = "R2";
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 64; i++) begin
        int bs, sl;
        if (c == 0) begin bs = i * 16; sl = 16; end
        else if (c == 1) begin bs = i * 8; sl = 8; end
        else begin bs = (i * 16 + 40 > 1000) ? 1000 : i * 16 + 40; sl = 60; end
        cyc(0, 0, 0, 0, 1, c * 256 + i, tagWord(bs, sl));
      end
    idle(2);

    // R3: interpolation across many segments and offsets
    tag = "R3";
    for (int k = 0; k < 100; k++)
      cyc(1, (k * 37) % 1024, (k * 53 + 11) % 1024, (k * 71 + 5) % 1024, 0, 0, 0);
    idle(2);

    // R4: top of red range overflows and clips
    tag = "R4";
    for (int p = 992; p < 1024; p++) cyc(1, p, p, p, 0, 0, 0);
    idle(2);

    // R6: valid gaps carrying noise
    tag = "R6";
    for (int k = 0; k < 40; k++)
      cyc(k % 3 == 0, $urandom_range(0, 1023), $urandom_range(0, 1023), $urandom_range(0, 1023), 0, 0, 0);
    idle(2);

    // R5: isolated pixels
    tag = "R5";
    for (int k = 0; k < 6; k++) begin
      cyc(1, 100 + k * 90, 200 + k * 70, 300 + k * 50, 0, 0, 0);
      idle(k % 3);
    end
    idle(2);

    // R7: write to blue entry 3 alongside a pixel in segment 3, then again
    tag = "R7";
    cyc(1, 53, 53, 53, 1, 3, tagWord(777, 33));
    cyc(1, 53, 53, 53, 0, 0, 0);
    cyc(1, 62, 62, 62, 1, 256 + 3, tagWord(5, 500));
    cyc(1, 62, 62, 62, 0, 0, 0);
    idle(3);

    // R8: reserved addresses leave entry 9 of every table untouched
    tag = "R8";
    cyc(0, 0, 0, 0, 1, 768 + 9, tagWord(900, 900));
    cyc(0, 0, 0, 0, 1, 64 + 9, tagWord(901, 901));
    cyc(0, 0, 0, 0, 1, 256 + 128 + 9, tagWord(902, 902));
    cyc(0, 0, 0, 0, 1, 512 + 192 + 9, tagWord(903, 903));
    for (int o = 0; o < 16; o += 5) cyc(1, 144 + o, 144 + o, 144 + o, 0, 0, 0);
    idle(3);

    // R1: green entry 20 alone rewritten, then one curve on all channels
    tag = "R1";
    cyc(0, 0, 0, 0, 1, 256 + 20, tagWord(11, 0));
    for (int o = 0; o < 16; o += 4) cyc(1, 320 + o, 320 + o, 320 + o, 0, 0, 0);
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 64; i++) cyc(0, 0, 0, 0, 1, c * 256 + i, tagWord(i * 16, 16));
    for (int k = 0; k < 40; k++)
      cyc(1, (k * 29) % 1024, (k * 41 + 3) % 1024, (k * 17 + 9) % 1024, 0, 0, 0);
    idle(3);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog %s actual timeout expected completion", tag);
      summary();
      $finish;
    end
  end
endmodule